// File: doc/BRIEF.md
# Branch and Next-PC Unit

This block chooses the address of the next instruction for a processor with 32-bit, word-aligned instructions. It holds the program counter in a register. On each enabled clock edge the register moves to the sequential address, or to a PC-relative branch target when a conditional branch resolves as taken.

The decoder supplies two one-hot strobes: one for branch-on-equal and one for branch-on-unequal. The register file supplies the two operands being compared. The instruction supplies a 16-bit signed word offset. The target is the address of the following instruction plus the offset times four. No flags are kept: the only condition tested is equality between the two operands. Magnitude tests must already have been reduced to a zero/non-zero register value before the branch.

Every pin is a plain control or data signal. No valid/ready stream exists here, because the unit produces one address per enabled cycle and has nothing to back-pressure. A low enable holds the PC.

Top module: `npc_unit`

## Requirements
- R1: While reset (`rst_n` low, synchronous) is applied, the PC register becomes 0 at the next rising edge.
- R2: With neither branch strobe high, `taken` is 0 and `npc` equals `pc + 4`.
- R3: With `is_beq` high, `taken` is 1 exactly when `opa == opb`. When it is taken, `npc` is the branch target; otherwise `npc` is `pc + 4`.
- R4: With `is_bne` high, `taken` is 1 exactly when `opa != opb`. When it is taken, `npc` is the branch target; otherwise `npc` is `pc + 4`.
- R5: The branch target is `pc + 4 + (sext32(imm) << 2)`. Here sext32 copies `imm[15]` into bits 31..16, so a negative offset branches backward.
- R6: All address sums wrap modulo 2^32.
- R7: On a rising edge with `en` high, `pc` takes the value `npc` showed before that edge. With `en` low, `pc` holds its value.
- R8: Bits 1..0 of `pc` and `npc` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | PC update enable |
| is_beq | input | 1 | Decoded branch-on-equal |
| is_bne | input | 1 | Decoded branch-on-unequal |
| opa | input | 32 | First compared operand |
| opb | input | 32 | Second compared operand |
| imm | input | 16 | Signed word offset |
| pc | output | 32 | Current program counter |
| npc | output | 32 | Next program counter (combinational) |
| taken | output | 1 | Branch resolved as taken |

## Verification
The assertions check four things on every cycle: alignment of `pc` and `npc`, the PC register following `npc` when enabled, holding its value when disabled, and `taken` staying low when no strobe is high. Only the bench scenarios can show the actual branch arithmetic. That covers the exact target values for forward and backward offsets, the extreme offsets, wrap-around at the top of the address space, and the equal/unequal decision on chosen operand pairs.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int unsigned AW = 32;
  localparam int unsigned OFFW = 16;
  localparam int unsigned INSTR_BYTES = 4;
  localparam int unsigned ALIGN_BITS = $clog2(INSTR_BYTES);
  typedef logic [AW-1:0] addr_t;
endpackage

// File: rtl/npc_cond.sv
module npc_cond #(
  parameter int unsigned DW = 32
) (
  input  logic          is_beq,
  input  logic          is_bne,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  output logic          taken
);
  logic same;
  always_comb begin
    same  = (opa == opb);
    taken = (is_beq & same) | (is_bne & ~same);
  end
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
(
  input  addr_t           pc,
  input  logic [OFFW-1:0] imm,
  output addr_t           seq,
  output addr_t           tgt
);
  addr_t disp;
  always_comb begin
    seq  = pc + addr_t'(INSTR_BYTES);
    disp = addr_t'({{(AW-OFFW){imm[OFFW-1]}}, imm}) << ALIGN_BITS;
    tgt  = seq + disp;
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        is_beq,
  input  logic        is_bne,
  input  logic [31:0] opa,
  input  logic [31:0] opb,
  input  logic [15:0] imm,
  output logic [31:0] pc,
  output logic [31:0] npc,
  output logic        taken
);
  addr_t pc_q, seq_a, tgt_a;
  logic  tk;

  npc_cond #(.DW(32)) u_cond (
    .is_beq(is_beq), .is_bne(is_bne), .opa(opa), .opb(opb), .taken(tk)
  );

  npc_target u_tgt (.pc(pc_q), .imm(imm), .seq(seq_a), .tgt(tgt_a));

  always_comb npc = tk ? tgt_a : seq_a;

  always_ff @(posedge clk) begin
    if (!rst_n)  pc_q <= '0;
    else if (en) pc_q <= npc;
  end

  assign pc    = pc_q;
  assign taken = tk;

  // R8
  a_r8_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (pc[1:0] == 2'b00) && (npc[1:0] == 2'b00));
  // R7
  a_r7_follow: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (pc == $past(npc)));
  // R7
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(pc));
  // R2
  a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_beq && !is_bne) |-> (!taken && npc == pc + 32'd4));
  // R1
  a_r1_reset: assert property (@(posedge clk)
    !rst_n |=> (pc == 32'd0));
endmodule

// File: tb/npc_unit_test.sv
module npc_unit_test;
  logic clk = 0, rst_n = 0, en = 0, is_beq = 0, is_bne = 0;
  logic [31:0] opa = 0, opb = 0;
  logic [15:0] imm = 0;
  logic [31:0] pc, npc;
  logic taken;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  npc_unit uut (.clk(clk), .rst_n(rst_n), .en(en), .is_beq(is_beq),
    .is_bne(is_bne), .opa(opa), .opb(opb), .imm(imm), .pc(pc),
    .npc(npc), .taken(taken));

  function automatic logic [31:0] target(input logic [31:0] p, input logic [15:0] i);
    logic [31:0] s;
    s = {{16{i[15]}}, i};
    return p + 32'd4 + (s * 32'd4);
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // load pc by a taken beq from current pc
  task automatic load_pc(input logic [31:0] want);
    @(negedge clk);
    rst_n = 0; en = 1; is_beq = 0; is_bne = 0;
    @(negedge clk);
    rst_n = 1;
    while (pc != want) begin
      logic [31:0] d;
      d = want - pc - 32'd4;
      if ($signed(d) > 32'sd131068 || $signed(d) < -32'sd131072)
        imm = ($signed(d) > 0) ? 16'h7fff : 16'h8000;
      else imm = d[17:2];
      is_beq = 1; opa = 1; opb = 1;
      @(negedge clk);
    end
    is_beq = 0; en = 0;
  endtask

  task automatic t_reset;
    @(negedge clk); rst_n = 0; en = 1;
    @(negedge clk);
    chk("R1 pc after reset", pc, 32'd0);
    rst_n = 1;
  endtask

  task automatic t_seq;
    load_pc(32'h100);
    is_beq = 0; is_bne = 0; #1;
    chk("R2 taken idle", {31'd0, taken}, 32'd0);
    chk("R2 npc idle", npc, 32'h104);
    en = 1; @(negedge clk);
    chk("R7 pc advanced", pc, 32'h104);
    en = 0; @(negedge clk);
    chk("R7 pc held", pc, 32'h104);
  endtask

  task automatic t_beq;
    load_pc(32'h200);
    is_beq = 1; opa = 32'h5; opb = 32'h5; imm = 16'h0010; #1;
    chk("R3 beq equal taken", {31'd0, taken}, 32'd1);
    chk("R3 beq target", npc, target(32'h200, 16'h0010));
    opb = 32'h6; #1;
    chk("R3 beq unequal fall", npc, 32'h204);
    chk("R8 npc aligned", {30'd0, npc[1:0]}, 32'd0);
    is_beq = 0;
  endtask

  task automatic t_bne;
    load_pc(32'h300);
    is_bne = 1; opa = 32'h80000000; opb = 32'h0; imm = 16'hfffc; #1;
    chk("R4 bne taken", {31'd0, taken}, 32'd1);
    chk("R5 backward target", npc, 32'h300 + 4 - 16);
    opb = 32'h80000000; #1;
    chk("R4 bne equal fall", npc, 32'h304);
    chk("R4 bne not taken", {31'd0, taken}, 32'd0);
    is_bne = 0;
  endtask

  task automatic t_extremes;
    load_pc(32'h00040000);
    is_beq = 1; opa = 0; opb = 0; imm = 16'h7fff; #1;
    chk("R5 max forward", npc, 32'h00040000 + 4 + 32'h1fffc);
    imm = 16'h8000; #1;
    chk("R5 max backward", npc, 32'h00040000 + 4 - 32'h20000);
    en = 1; @(negedge clk); en = 0;
    chk("R7 pc took branch", pc, 32'h00020004);
    is_beq = 0;
  endtask

  task automatic t_wrap;
    load_pc(32'h0);
    is_beq = 1; opa = 0; opb = 0; imm = 16'hfffe; #1;
    chk("R6 wrap backward", npc, 32'hfffffffc);
    en = 1; @(negedge clk);
    is_beq = 0; #1;
    chk("R6 wrap sequential", npc, 32'h0);
    en = 0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_seq();
    t_beq();
    t_bne();
    t_extremes();
    t_wrap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule